// File: doc/BRIEF.md
# Configuration Word Streamer

This block takes 32-bit configuration words from a writer and places them on a parallel configuration bus, together with a data clock (`dclk`). The bus is 16 or 32 bits wide. In narrow mode each word leaves as two halfword beats. Each beat is held on the bus for 1, 2, 4 or 8 data-clock pulses, chosen by a 2-bit ratio code. The last word of a stream may carry only 1, 2 or 3 valid bytes. For such a word the block zeroes the unused upper bytes before sending it.

The writer side is a valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is held low while a word is still being streamed out and while `xfer_en` is low, and the writer must then keep its word and wait. The width, ratio and enable inputs are plain levels from a control register held elsewhere. Width and ratio are sampled when a word is taken. If `xfer_en` drops during a word, the beat in progress runs to its end, the rest of the word is discarded, and the block goes idle.

Top module: `cfgword_streamer`

## Requirements
- R1: After reset `dclk` is 0, `cfg_data` is 0, and `in_ready` equals `xfer_en`.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. From the next cycle `in_ready` stays low until every beat of that word has been sent, and `in_ready` is never high while `dclk` is high.
- R3: While `xfer_en` is 0, `in_ready` is 0, no word is accepted, and `dclk` does not pulse.
- R4: With `wide_sel`=1 at acceptance, the word goes out as one beat carrying all 32 bits on `cfg_data`.
- R5: With `wide_sel`=0 at acceptance, the word goes out as two beats on `cfg_data[15:0]` with `cfg_data[31:16]`=0. Bits [15:0] go first and bits [31:16] second.
- R6: Each beat carries 2^`ratio_sel` `dclk` pulses (code 0→1, 1→2, 2→4, 3→8). Each pulse is one cycle low followed by one cycle high, so a beat lasts 2^(`ratio_sel`+1) cycles and a new beat always opens with `dclk` low.
- R7: `cfg_data` does not change in any cycle where `dclk` is high. It changes only at the edge that starts a beat, and that edge drives `dclk` low.
- R8: `in_tail_bytes` gives the count of valid low bytes. The value 0 means all four bytes are valid. The values 1, 2 and 3 keep that many low bytes and send the upper bytes as zero.
- R9: Changes to `wide_sel` or `ratio_sel` after a word is accepted have no effect on that word.
- R10: If `xfer_en` is 0 at the end of a beat, the remaining beats of the word are dropped and the block returns to idle. `cfg_data` keeps the last beat sent.
- R11: When `xfer_en` stays high, `in_ready` rises in the cycle right after the last high phase of the final beat, so words can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_en | input | 1 | Transfer enable level |
| wide_sel | input | 1 | Bus width: 0 = 16 bits, 1 = 32 bits |
| ratio_sel | input | 2 | Pulses per beat = 2^ratio_sel |
| in_valid | input | 1 | Writer has a word |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 32 | Configuration word |
| in_tail_bytes | input | 2 | Valid low bytes (0 = all four) |
| cfg_data | output | 32 | Configuration bus |
| dclk | output | 1 | Data clock to the configured device |

## Verification
Take the edge that accepts a word as edge 0. The first beat is on `cfg_data` with `dclk` low from edge 0. `dclk` then goes high after every odd edge. For N pulses per beat and B beats, `in_ready` is low for exactly 2·N·B cycles and returns high after edge 2·N·B. The bench counts the low-ready cycles from the accepting edge and compares the count with this arithmetic. It samples `cfg_data` at every rising `dclk`, half a clock after the edge, and compares the samples with the masked word split into beats. The sweep covers every width, ratio and tail-byte combination. Aborts are checked a fixed number of cycles after the last beat could have ended.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int CFS_WORD_W = 32;
  localparam int CFS_BYTES  = CFS_WORD_W / 8;

  typedef logic [CFS_WORD_W-1:0] cfs_word_t;

  // Keep the low nb bytes; nb == 0 keeps the whole word.
  function automatic cfs_word_t cfs_keep_bytes(cfs_word_t w, logic [1:0] nb);
    cfs_word_t r;
    for (int b = 0; b < CFS_BYTES; b++) begin
      r[b*8 +: 8] = ((nb == 2'd0) || (b < int'(nb))) ? w[b*8 +: 8] : 8'h00;
    end
    return r;
  endfunction
endpackage

// File: rtl/cfs_pulse_gen.sv
module cfs_pulse_gen #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] pulses_m1,
  output logic             dclk,
  output logic             beat_done
);
  logic [CNT_W-1:0] cnt_q;
  logic             dclk_q;

  assign dclk      = dclk_q;
  assign beat_done = run && dclk_q && (cnt_q == pulses_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else if (run) begin
      if (dclk_q) begin
        dclk_q <= 1'b0;
        cnt_q  <= cnt_q + 1'b1;
      end else begin
        dclk_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfs_beat_sel.sv
module cfs_beat_sel #(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 16,
  localparam int BEATS   = WORD_W / NARROW_W,
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic [WORD_W-1:0] word,
  input  logic              wide,
  input  logic [BEAT_W-1:0] beat,
  output logic [WORD_W-1:0] bus
);
  logic [NARROW_W-1:0] slice [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_slice
    assign slice[k] = word[k*NARROW_W +: NARROW_W];
  end

  always_comb begin
    if (wide) bus = word;
    else      bus = {{(WORD_W-NARROW_W){1'b0}}, slice[beat]};
  end
endmodule

// File: rtl/cfgword_streamer.sv
module cfgword_streamer
  import cfs_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int RATIO_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer_en,
  input  logic                  wide_sel,
  input  logic [RATIO_W-1:0]    ratio_sel,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CFS_WORD_W-1:0] in_data,
  input  logic [1:0]            in_tail_bytes,
  output logic [CFS_WORD_W-1:0] cfg_data,
  output logic                  dclk
);
  localparam int BEATS  = CFS_WORD_W / NARROW_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CNT_W  = (2 ** RATIO_W) - 1;

  logic                busy_q;
  logic                wide_q;
  logic [RATIO_W-1:0]  ratio_q;
  cfs_word_t           word_q;
  logic [BEAT_W-1:0]   beat_q;
  logic                accept;
  logic                beat_done;
  logic                last_beat;
  logic [CNT_W:0]      pulse_onehot;
  logic [CNT_W-1:0]    pulses_m1;

  assign in_ready  = xfer_en && !busy_q;
  assign accept    = in_valid && in_ready;
  assign last_beat = wide_q || (beat_q == BEAT_W'(BEATS - 1));

  assign pulse_onehot = (CNT_W+1)'(1) << ratio_q;
  assign pulses_m1    = CNT_W'(pulse_onehot - (CNT_W+1)'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wide_q  <= 1'b0;
      ratio_q <= '0;
      word_q  <= '0;
      beat_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      wide_q  <= wide_sel;
      ratio_q <= ratio_sel;
      word_q  <= cfs_keep_bytes(in_data, in_tail_bytes);
      beat_q  <= '0;
    end else if (beat_done) begin
      if (!xfer_en || last_beat) busy_q <= 1'b0;
      else                       beat_q <= beat_q + 1'b1;
    end
  end

  cfs_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_q),
    .restart   (accept || beat_done),
    .pulses_m1 (pulses_m1),
    .dclk      (dclk),
    .beat_done (beat_done)
  );

  cfs_beat_sel #(.WORD_W(CFS_WORD_W), .NARROW_W(NARROW_W)) u_sel (
    .word (word_q),
    .wide (wide_q),
    .beat (beat_q),
    .bus  (cfg_data)
  );
endmodule

// File: rtl/cfgword_streamer_chk.sv
module cfgword_streamer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_en,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] cfg_data,
  input logic        dclk
);
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $stable(cfg_data));

  // R6
  dclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |=> !dclk);

  // R6
  beat_opens_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !dclk);

  // R3
  en_gates_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |-> !in_ready);

  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> !in_ready);
endmodule

bind cfgword_streamer cfgword_streamer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xfer_en  (xfer_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .cfg_data (cfg_data),
  .dclk     (dclk)
);

// File: tb/cfgword_streamer_test.sv
module cfgword_streamer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_en = 1'b0;
  logic        wide_sel = 1'b0;
  logic [1:0]  ratio_sel = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_tail_bytes = 2'd0;
  logic [31:0] cfg_data;
  logic        dclk;

  int checks = 0;
  int errors = 0;

  logic [31:0] cap_log [1024];
  int          cap_total = 0;
  logic        prev_dclk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgword_streamer uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_en       (xfer_en),
    .wide_sel      (wide_sel),
    .ratio_sel     (ratio_sel),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .in_tail_bytes (in_tail_bytes),
    .cfg_data      (cfg_data),
    .dclk          (dclk)
  );

  // Capture bus value at each rising dclk, half a clock after the edge.
  always @(negedge clk) begin
    if (dclk && !prev_dclk) begin
      cap_log[cap_total % 1024] = cfg_data;
      cap_total = cap_total + 1;
    end
    prev_dclk = dclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep(input logic [31:0] d, input logic [1:0] nb);
    case (nb)
      2'd1:    return d & 32'h0000_00FF;
      2'd2:    return d & 32'h0000_FFFF;
      2'd3:    return d & 32'h00FF_FFFF;
      default: return d;
    endcase
  endfunction

  // Send one word, flip width/ratio after acceptance, count busy cycles.
  task automatic send_and_check(input logic [31:0] d, input logic [1:0] nb,
                                input logic w, input logic [1:0] r);
    int start;
    int busy;
    int n;
    int beats;
    bit ok;
    logic [31:0] m;
    logic [31:0] exp;
    while (!in_ready) @(negedge clk);
    start = cap_total;
    in_data = d; in_tail_bytes = nb; wide_sel = w; ratio_sel = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wide_sel = ~w; ratio_sel = ~r;  // R9: must not affect the word in flight
    busy = 0;
    while (!in_ready && busy < 100) begin
      busy++;
      @(negedge clk);
    end
    n = 1 << r;
    beats = w ? 1 : 2;
    m = keep(d, nb);
    // R2 R6 R11: ready low for exactly 2*N*B cycles
    chk(busy == 2*n*beats, "R11 busy cycles", busy, 2*n*beats);
    chk(cap_total - start == n*beats, "R6 pulse count", cap_total - start, n*beats);
    ok = 1'b1;
    exp = '0;
    for (int i = 0; i < n*beats; i++) begin
      if (w) exp = m;                                // R4
      else if (i < n) exp = {16'h0, m[15:0]};       // R5
      else exp = {16'h0, m[31:16]};
      if (cap_log[(start + i) % 1024] !== exp) begin
        ok = 1'b0;
        chk(1'b0, "R8 beat data", cap_log[(start + i) % 1024], exp);
      end
    end
    if (ok) chk(1'b1, "R4 R5 R8 beat data", 32'h0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    // R1: reset state, enable low
    chk(in_ready == 1'b0, "R1 ready with en low", 32'(in_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dclk == 1'b0, "R1 dclk after reset", 32'(dclk), 32'd0);
    chk(cfg_data == 32'h0, "R1 cfg_data after reset", cfg_data, 32'h0);
    xfer_en = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready follows en", 32'(in_ready), 32'd1);

    // R3: disabled writer is stalled
    xfer_en = 1'b0;
    in_valid = 1'b1;
    in_data = 32'hDEAD_BEEF;
    start = cap_total;
    repeat (12) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R3 ready low while disabled", 32'(in_ready), 32'd0);
    end
    chk(cap_total == start, "R3 no dclk while disabled", cap_total - start, 0);
    chk(cfg_data == 32'h0, "R3 bus untouched", cfg_data, 32'h0);
    in_valid = 1'b0;
    xfer_en = 1'b1;
    @(negedge clk);

    // Sweep width x ratio x tail bytes (R4 R5 R6 R8 R9 R11)
    for (int w = 0; w < 2; w++)
      for (int r = 0; r < 4; r++)
        for (int nb = 0; nb < 4; nb++)
          send_and_check(32'h8E3C_71A5 ^ (32'((w*16 + r*4 + nb)) * 32'h0123_4567),
                         2'(nb), 1'(w), 2'(r));

    // R10: abort in first narrow beat, ratio 4
    while (!in_ready) @(negedge clk);
    start = cap_total;
    in_data = 32'h1357_9BDF; in_tail_bytes = 2'd0; wide_sel = 1'b0;
    ratio_sel = 2'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    xfer_en = 1'b0;
    repeat (30) @(negedge clk);
    chk(cap_total - start == 4, "R10 only first beat pulses", cap_total - start, 4);
    chk(cfg_data == 32'h0000_9BDF, "R10 bus holds first beat", cfg_data, 32'h0000_9BDF);
    chk(dclk == 1'b0, "R10 dclk idle low", 32'(dclk), 32'd0);
    xfer_en = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 idle after abort", 32'(in_ready), 32'd1);

    // R10: abort during a wide word still completes its single beat
    start = cap_total;
    in_data = 32'hCAFE_0042; wide_sel = 1'b1; ratio_sel = 2'd3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    xfer_en = 1'b0;
    repeat (30) @(negedge clk);
    chk(cap_total - start == 8, "R10 wide beat finishes", cap_total - start, 8);
    chk(cfg_data == 32'hCAFE_0042, "R10 wide data", cfg_data, 32'hCAFE_0042);
    xfer_en = 1'b1;

    // R11: back-to-back words after an abort
    send_and_check(32'h0F0F_F0F0, 2'd0, 1'b0, 2'd0);
    send_and_check(32'hA1B2_C3D4, 2'd3, 1'b1, 2'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule